// File: doc/BRIEF.md
# Pipelined Linear-Array Key-Pointer Sorter

This block sorts streams of key-pointer pairs on a chain of NUM/2 identical cells. Each cell has an upper and a lower slot and one comparator. Every accepted step does two things. First, one row of slots moves by one cell. Then every cell compares its two entries, and may swap them, at the same time. Each step takes in one pair at one end of the chain and hands out one pair at an end. The sorting work is therefore hidden inside the time spent moving data in and out.

The block runs in phases of NUM steps. In one phase, the lower slots move right: new pairs enter at the left and leave at the right. In the next phase, the upper slots move left: new pairs enter at the right and leave at the left. A sequence loaded during one phase comes out, in order, during the next phase. Meanwhile the following sequence is loading. Every stored pair carries a one-bit mark of the end it came in from. Pairs with different marks always trade places and are never compared. Because of these marks, sequences can follow each other back to back with no clearing of the array.

A slot with no data is held as an empty entry. The empty entry is marked by a flag bit, not by a key value, and it always sorts after every real key. One control pin chooses ascending or descending order. With the STABLE parameter set, the step number within the phase is appended below the key, so that equal keys leave in the order they arrived.

Top module: `keypair_sorter`

## Requirements
- R1: After reset every slot is empty and out_side is 1. The first NUM accepted steps produce no out_valid.
- R2: In ascending mode (descending=0), a sequence loaded during one phase leaves during the next phase in non-decreasing key order. Each key leaves with the pointer it entered with.
- R3: out_side changes after every NUM accepted steps. out_side=1 means pairs leave at the right end and enter at the left. out_side=0 means pairs leave at the left end and enter at the right.
- R4: Sequences of NUM pairs presented back to back are each sorted correctly with no clearing in between. While a full sequence is draining, out_valid is high on every accepted step.
- R5: A step with in_valid=0 inserts an empty entry. A sequence of fewer than NUM pairs is sorted correctly, and only its real pairs are emitted.
- R6: With descending=1, the pairs of a sequence leave in non-increasing key order.
- R7: With STABLE=1, pairs with equal keys leave in the order they entered, at both ends of the array.
- R8: Key values 0 and all-ones sort as ordinary keys. An empty entry never raises out_valid.
- R9: While out_valid=1 and out_ready=0, no step happens: in_ready is 0, and out_key and out_ptr hold their values.
- R10: While step_en=0, in_ready and out_valid are 0, and the stored contents do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| descending | input | 1 | 1 selects descending order; change only when the array holds no data |
| step_en | input | 1 | Allows a step in this cycle |
| in_valid | input | 1 | A pair is offered; when low, a step inserts an empty entry |
| in_ready | output | 1 | A step is taken in this cycle |
| in_key | input | KEY_W | Key of the offered pair |
| in_ptr | input | PTR_W | Pointer of the offered pair |
| out_valid | output | 1 | The pair at the exit end holds data |
| out_ready | input | 1 | The consumer accepts the exiting pair |
| out_key | output | KEY_W | Key of the exiting pair |
| out_ptr | output | PTR_W | Pointer of the exiting pair |
| out_side | output | 1 | Exit end of the current phase: 1 is right, 0 is left |

## Verification
A wrong swap decision in any cell is only visible at the ports one phase later. It shows up as an out-of-order key, a pointer paired with the wrong key, or a pair missing from the drained sequence. A fault in the mark of which end a pair came from usually makes a pair leave at the wrong end or during the wrong phase. That changes the number of pairs emitted in a phase, which a count per phase catches. A fault in the step counter shows within NUM steps as an out_side flip on the wrong step. A stall fault shows in the same cycle, as a step taken while out_ready is low.

// File: rtl/keypair_sorter.sv
module keypair_sorter #(
  parameter int KEY_W  = 8,
  parameter int PTR_W  = 8,
  parameter int NUM    = 8,
  parameter int STABLE = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             descending,
  input  logic             step_en,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [KEY_W-1:0] in_key,
  input  logic [PTR_W-1:0] in_ptr,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [KEY_W-1:0] out_key,
  output logic [PTR_W-1:0] out_ptr,
  output logic             out_side
);
  localparam int CELLS = NUM / 2;
  localparam int SW    = (NUM > 2) ? $clog2(NUM) : 1;
  localparam int EW    = 2 + KEY_W + SW + PTR_W;
  localparam int P_S   = PTR_W;
  localparam int P_K   = PTR_W + SW;
  localparam int P_T   = P_K + KEY_W;
  localparam int P_E   = P_T + 1;
  localparam logic [SW-1:0] LAST = SW'(NUM - 1);
  localparam logic [EW-1:0] HOLE = {1'b1, {(EW-1){1'b0}}};

  function automatic logic ahead(input logic [EW-1:0] a, input logic [EW-1:0] b,
                                 input logic desc);
    logic [KEY_W-1:0] ka, kb;
    ka = a[P_K +: KEY_W];
    kb = b[P_K +: KEY_W];
    if (a[P_E]) return 1'b0;
    if (b[P_E]) return 1'b1;
    if (ka != kb) return desc ? (ka > kb) : (ka < kb);
    if (STABLE != 0) return a[P_S +: SW] < b[P_S +: SW];
    return 1'b0;
  endfunction

  logic            right_out;
  logic [SW-1:0]   seq_pos;
  logic [EW-1:0]   up_q [CELLS];
  logic [EW-1:0]   lo_q [CELLS];
  logic [EW-1:0]   exit_e, entry_e;
  logic            advance;

  assign exit_e    = right_out ? lo_q[CELLS-1] : up_q[0];
  assign out_valid = step_en & ~exit_e[P_E];
  assign advance   = step_en & (exit_e[P_E] | out_ready);
  assign in_ready  = advance;
  assign out_key   = exit_e[P_K +: KEY_W];
  assign out_ptr   = exit_e[PTR_W-1:0];
  assign out_side  = right_out;
  assign entry_e   = {~in_valid, ~right_out, in_key, seq_pos, in_ptr};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      right_out <= 1'b1;
      seq_pos   <= '0;
    end else if (advance) begin
      if (seq_pos == LAST) begin
        seq_pos   <= '0;
        right_out <= ~right_out;
      end else begin
        seq_pos <= seq_pos + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    logic [EW-1:0] u_r, l_r, u_src, l_src, u_sh, l_sh, u_nx, l_nx;

    if (i == CELLS - 1) begin : g_redge
      assign u_src = entry_e;
    end else begin : g_rin
      assign u_src = up_q[i+1];
    end
    if (i == 0) begin : g_ledge
      assign l_src = entry_e;
    end else begin : g_lin
      assign l_src = lo_q[i-1];
    end

    assign u_sh = right_out ? u_r : u_src;
    assign l_sh = right_out ? l_src : l_r;

    always_comb begin
      u_nx = u_sh;
      l_nx = l_sh;
      if (u_sh[P_T] != l_sh[P_T]) begin
        u_nx = l_sh;
        l_nx = u_sh;
      end else if (!u_sh[P_T]) begin
        if (ahead(l_sh, u_sh, descending)) begin
          u_nx = l_sh;
          l_nx = u_sh;
        end
      end else if (ahead(u_sh, l_sh, descending)) begin
        u_nx = l_sh;
        l_nx = u_sh;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        u_r <= HOLE;
        l_r <= HOLE;
      end else if (advance) begin
        u_r <= u_nx;
        l_r <= l_nx;
      end
    end

    assign up_q[i] = u_r;
    assign lo_q[i] = l_r;
  end
endmodule

// File: rtl/keypair_sorter_chk.sv
module keypair_sorter_chk #(
  parameter int KEY_W = 8,
  parameter int NUM   = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             descending,
  input logic             step_en,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [KEY_W-1:0] out_key,
  input logic             out_side
);
  int               scnt;
  logic [KEY_W-1:0] last_key;
  logic             have_last, side_q;
  logic             fire;

  assign fire = out_valid & out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scnt      <= 0;
      last_key  <= '0;
      have_last <= 1'b0;
      side_q    <= 1'b1;
    end else begin
      side_q <= out_side;
      if (in_ready) scnt <= (scnt == NUM - 1) ? 0 : scnt + 1;
      if (fire) begin
        last_key  <= out_key;
        have_last <= 1'b1;
      end else if (out_side != side_q) begin
        have_last <= 1'b0;
      end
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |-> (!in_ready && !out_valid)); // R10

  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R9

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (!step_en || (out_valid && $stable(out_key)))); // R9

  AST_SIDE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && scnt == NUM - 1) |=> (out_side != $past(out_side))); // R3

  AST_SIDE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && scnt == NUM - 1) |=> $stable(out_side)); // R3

  AST_ASC_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && have_last && out_side == side_q && !descending) |-> out_key >= last_key); // R2

  AST_DESC_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && have_last && out_side == side_q && descending) |-> out_key <= last_key); // R6
endmodule

bind keypair_sorter keypair_sorter_chk #(.KEY_W(KEY_W), .NUM(NUM)) chk_i (
  .clk(clk), .rst_n(rst_n), .descending(descending), .step_en(step_en),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_key(out_key), .out_side(out_side));

// File: tb/keypair_sorter_tb_top.sv
module keypair_sorter_tb_top;
  localparam int KW  = 8;
  localparam int PW  = 8;
  localparam int NUM = 8;

  logic          clk, rst_n, descending, step_en, in_valid, out_ready;
  logic          in_ready, out_valid, out_side;
  logic [KW-1:0] in_key, out_key;
  logic [PW-1:0] in_ptr, out_ptr;

  keypair_sorter #(.KEY_W(KW), .PTR_W(PW), .NUM(NUM), .STABLE(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .descending(descending), .step_en(step_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_key(in_key), .in_ptr(in_ptr),
    .out_valid(out_valid), .out_ready(out_ready), .out_key(out_key),
    .out_ptr(out_ptr), .out_side(out_side));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  bit exp_side = 1;
  logic [KW-1:0] stim_k [NUM];
  logic [PW-1:0] stim_p [NUM];
  logic [KW-1:0] prev_k [NUM];
  logic [PW-1:0] prev_p [NUM];
  logic [KW-1:0] got_k  [NUM];
  logic [PW-1:0] got_p  [NUM];
  int prev_n = 0, got_n;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit later(input logic [KW-1:0] a, input logic [KW-1:0] b);
    return descending ? (a < b) : (a > b);
  endfunction

  task automatic run_phase(input int n_real, input string req);
    int side0 = 0;
    got_n = 0;
    for (int s = 0; s < NUM; s++) begin
      step_en  = 1'b1;
      in_valid = (s < n_real);
      in_key   = stim_k[s];
      in_ptr   = stim_p[s];
      @(negedge clk);
      if (s == 0) side0 = int'(out_side);
      if (out_valid && in_ready) begin
        if (got_n < NUM) begin
          got_k[got_n] = out_key;
          got_p[got_n] = out_ptr;
        end
        got_n++;
      end
      @(posedge clk); #1;
    end
    step_en  = 1'b0;
    in_valid = 1'b0;
    chk(side0 == int'(exp_side), "R3", "exit side", side0, int'(exp_side));
    exp_side = !exp_side;
    chk(got_n == prev_n, req, "pairs emitted", got_n, prev_n);
    for (int i = 0; i < prev_n && i < got_n; i++) begin
      chk(got_k[i] == prev_k[i], req, $sformatf("key %0d", i), got_k[i], prev_k[i]);
      chk(got_p[i] == prev_p[i], req, $sformatf("ptr %0d", i), got_p[i], prev_p[i]);
    end
    prev_n = n_real;
    for (int i = 0; i < n_real; i++) begin
      int j = i;
      while (j > 0 && later(prev_k[j-1], stim_k[i])) begin
        prev_k[j] = prev_k[j-1];
        prev_p[j] = prev_p[j-1];
        j--;
      end
      prev_k[j] = stim_k[i];
      prev_p[j] = stim_p[i];
    end
  endtask

  task automatic fill(input int base);
    for (int i = 0; i < NUM; i++) begin
      stim_k[i] = KW'(((i * 3) % NUM) * 20 + base);
      stim_p[i] = PW'(i + base);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(out_side == 1'b1, "R1", "out_side after reset", out_side, 1);
    chk(in_ready == 1'b0 && out_valid == 1'b0, "R10", "idle handshake",
        {in_ready, out_valid}, 0);
    step_en = 1'b1;
    #1;
    chk(out_valid == 1'b0, "R1", "empty exit", out_valid, 0);
    chk(in_ready == 1'b1, "R1", "step allowed", in_ready, 1);
    step_en = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic t_basic();
    fill(7);
    run_phase(NUM, "R1");
    run_phase(0, "R2");
  endtask

  task automatic t_overlap();
    fill(11);  run_phase(NUM, "R4");
    fill(2);   run_phase(NUM, "R4");
    fill(40);  run_phase(NUM, "R4");
    run_phase(0, "R4");
  endtask

  task automatic t_short();
    fill(5);
    run_phase(5, "R5");
    run_phase(0, "R5");
  endtask

  task automatic t_stable();
    for (int i = 0; i < NUM; i++) begin
      stim_k[i] = (i % 2 == 0) ? 8'd7 : 8'd3;
      stim_p[i] = PW'(i);
    end
    stim_k[5] = 8'd1;
    run_phase(NUM, "R7");
    for (int i = 0; i < NUM; i++) begin
      stim_k[i] = (i < 4) ? 8'd9 : 8'd4;
      stim_p[i] = PW'(100 + i);
    end
    run_phase(NUM, "R7");
    run_phase(0, "R7");
  endtask

  task automatic t_desc();
    descending = 1'b1;
    fill(3);   run_phase(NUM, "R6");
    fill(60);  run_phase(6, "R6");
    run_phase(0, "R6");
    descending = 1'b0;
  endtask

  task automatic t_extreme();
    fill(1);
    stim_k[0] = 8'd255;
    stim_k[1] = 8'd0;
    stim_k[2] = 8'd255;
    stim_k[3] = 8'd0;
    run_phase(4, "R8");
    run_phase(0, "R8");
  endtask

  task automatic t_stall();
    fill(9);
    run_phase(NUM, "R9");
    out_ready = 1'b0;
    step_en   = 1'b1;
    in_valid  = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b1, "R9", "exit valid", out_valid, 1);
    chk(in_ready == 1'b0, "R9", "in_ready under stall", in_ready, 0);
    chk(out_key == prev_k[0], "R9", "stalled key", out_key, prev_k[0]);
    @(posedge clk); #1;
    @(negedge clk);
    chk(out_key == prev_k[0], "R9", "held key", out_key, prev_k[0]);
    chk(out_ptr == prev_p[0], "R9", "held ptr", out_ptr, prev_p[0]);
    chk(in_ready == 1'b0, "R9", "still blocked", in_ready, 0);
    @(posedge clk); #1;
    out_ready = 1'b1;
    step_en   = 1'b0;
    run_phase(0, "R9");
  endtask

  task automatic t_idle();
    fill(13);
    run_phase(NUM, "R10");
    step_en  = 1'b0;
    in_valid = 1'b1;
    in_key   = 8'd0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk(out_valid == 1'b0 && in_ready == 1'b0, "R10", "quiet while disabled",
          {out_valid, in_ready}, 0);
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    run_phase(0, "R10");
  endtask

  initial begin
    rst_n = 1'b0; descending = 1'b0; step_en = 1'b0; in_valid = 1'b0;
    out_ready = 1'b1; in_key = '0; in_ptr = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_basic();
    t_overlap();
    t_short();
    t_stable();
    t_desc();
    t_extreme();
    t_stall();
    t_idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 50000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired: actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule